// File: doc/BRIEF.md
# Single-Step Shifting Register with Sign-Change Flag

This block is a clocked register, `W` bits wide (8 by default). On each enabled rising clock edge it performs one operation chosen by a 3-bit code. The operations are a parallel load, a clear, and a one-position move to the left or right. A move belongs to one of three families: zero-fill, rotate or signed. The families use the same lane multiplexers and differ only in the bit fed into the end that is vacated. Multi-position moves and external serial pins are not provided.

A registered flag reports whether the most recent signed left move changed the sign of the value. It is computed from the two top bits as they stood before the move. The flag is cleared together with the register by a load or a clear. It keeps its value through every other operation. Reset is synchronous and active high.

Top module: `bitshift_reg`

## Requirements
- R1: While `rst` is 1 at a rising edge, `q` becomes all zeros and `ovf` becomes 0 on that edge, whatever `en` and `op` are.
- R2: With `en`=1 and `op`=3'b000, `q` takes the value of `din` on the edge and `ovf` becomes 0.
- R3: With `en`=1 and `op`=3'b001 (zero-fill left), `q` becomes `{q[W-2:0],1'b0}`.
- R4: With `en`=1 and `op`=3'b010 (zero-fill right), `q` becomes `{1'b0,q[W-1:1]}`.
- R5: With `en`=1 and `op`=3'b011 (rotate left), `q` becomes `{q[W-2:0],q[W-1]}`.
- R6: With `en`=1 and `op`=3'b100 (rotate right), `q` becomes `{q[0],q[W-1:1]}`.
- R7: With `en`=1 and `op`=3'b101 (signed left), `q` becomes `{q[W-2:0],1'b0}` and `ovf` becomes `q[W-1]^q[W-2]`, both taken from before the edge.
- R8: With `en`=1 and `op`=3'b110 (signed right), `q` becomes `{q[W-1],q[W-1:1]}`, so the sign bit is kept.
- R9: With `en`=1 and `op`=3'b111, `q` becomes all zeros and `ovf` becomes 0.
- R10: With `en`=0, `q` and `ovf` keep their values for every `op` and `din`.
- R11: Under codes 001, 010, 011, 100 and 110 with `en`=1, `ovf` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Operation enable |
| op | input | 3 | Operation code |
| din | input | W | Parallel load value |
| q | output | W | Register contents |
| ovf | output | 1 | Sign-change flag of the last signed left move |

## Verification
Every operation takes one edge, so a wrong fill bit or a wrong lane selection shows at `q` on the edge right after the stimulus. For example, a rotate that loses its wrapped bit reads back a zero at the vacated end. A flag that is computed from the wrong bit pair, or from the value after the move, gives the wrong `ovf` on the same edge. A flag that is not held is seen on the following edge: a wrong hold under zero-fill, rotate or signed-right moves, or under a disabled cycle, changes `ovf` in that edge, before any load or clear clears it.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [2:0] {
    OP_LOAD = 3'b000,
    OP_LSL  = 3'b001,
    OP_LSR  = 3'b010,
    OP_ROL  = 3'b011,
    OP_ROR  = 3'b100,
    OP_ASL  = 3'b101,
    OP_ASR  = 3'b110,
    OP_CLR  = 3'b111
  } shop_e;

  // Moves toward the MSB
  function automatic logic op_is_left(shop_e o);
    return (o == OP_LSL) || (o == OP_ROL) || (o == OP_ASL);
  endfunction

  // Moves toward the LSB
  function automatic logic op_is_right(shop_e o);
    return (o == OP_LSR) || (o == OP_ROR) || (o == OP_ASR);
  endfunction

  // Bit entering the vacated end, from the pre-move end bits
  function automatic logic fill_bit(shop_e o, logic top, logic bot);
    case (o)
      OP_ROL:  return top;
      OP_ROR:  return bot;
      OP_ASR:  return top;
      default: return 1'b0;
    endcase
  endfunction

  // Sign changes on a left move when the two leading bits disagree
  function automatic logic sign_breaks(logic top, logic next_top);
    return top ^ next_top;
  endfunction

endpackage

// File: rtl/bshift_ctrl.sv
module bshift_ctrl
  import bshift_pkg::*;
(
  input  logic       en,
  input  logic [2:0] op,
  input  logic       top,
  input  logic       bot,
  output logic       do_load,
  output logic       do_clr,
  output logic       go_left,
  output logic       go_right,
  output logic       asl_fire,
  output logic       fill
);
  shop_e code;

  always_comb begin
    code     = shop_e'(op);
    do_load  = en && (code == OP_LOAD);
    do_clr   = en && (code == OP_CLR);
    go_left  = en && op_is_left(code);
    go_right = en && op_is_right(code);
    asl_fire = en && (code == OP_ASL);
    fill     = fill_bit(code, top, bot);
  end
endmodule

// File: rtl/bshift_lanes.sv
module bshift_lanes #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] din,
  input  logic         do_load,
  input  logic         do_clr,
  input  logic         go_left,
  input  logic         go_right,
  input  logic         fill,
  output logic [W-1:0] nxt
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    logic from_low;
    logic from_high;

    if (i == 0) begin : g_bot
      assign from_low = fill;
    end else begin : g_midl
      assign from_low = cur[i-1];
    end

    if (i == W-1) begin : g_top
      assign from_high = fill;
    end else begin : g_midh
      assign from_high = cur[i+1];
    end

    always_comb begin
      if (do_load)       nxt[i] = din[i];
      else if (do_clr)   nxt[i] = 1'b0;
      else if (go_left)  nxt[i] = from_low;
      else if (go_right) nxt[i] = from_high;
      else               nxt[i] = cur[i];
    end
  end
endmodule

// File: rtl/bshift_flag.sv
module bshift_flag
  import bshift_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic asl_fire,
  input  logic wipe,
  input  logic top,
  input  logic next_top,
  output logic flag
);
  logic flag_d;

  always_comb begin
    if (wipe)          flag_d = 1'b0;
    else if (asl_fire) flag_d = sign_breaks(top, next_top);
    else               flag_d = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= flag_d;
  end
endmodule

// File: rtl/bitshift_reg.sv
module bitshift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [2:0]   op,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         ovf
);
  localparam int TOP = W - 1;
  localparam int SUB = W - 2;

  logic [W-1:0] q_nxt;
  logic         do_load;
  logic         do_clr;
  logic         go_left;
  logic         go_right;
  logic         asl_fire;
  logic         fill;
  logic         wipe;

  initial begin
    if (W < 2) $error("bitshift_reg needs W >= 2");
  end

  bshift_ctrl u_ctrl (
    .en       (en),
    .op       (op),
    .top      (q[TOP]),
    .bot      (q[0]),
    .do_load  (do_load),
    .do_clr   (do_clr),
    .go_left  (go_left),
    .go_right (go_right),
    .asl_fire (asl_fire),
    .fill     (fill)
  );

  bshift_lanes #(.W(W)) u_lanes (
    .cur      (q),
    .din      (din),
    .do_load  (do_load),
    .do_clr   (do_clr),
    .go_left  (go_left),
    .go_right (go_right),
    .fill     (fill),
    .nxt      (q_nxt)
  );

  assign wipe = do_load || do_clr;

  bshift_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .asl_fire (asl_fire),
    .wipe     (wipe),
    .top      (q[TOP]),
    .next_top (q[SUB]),
    .flag     (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/bitshift_reg_chk.sv
module bitshift_reg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [2:0]   op,
  input logic [W-1:0] din,
  input logic [W-1:0] q,
  input logic         ovf,
  input logic         asl_fire
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(q) && $stable(ovf))); // R10

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'b000) |=> (q == $past(din) && !ovf)); // R2

  AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
    asl_fire |=> (ovf == ($past(q[W-1]) ^ $past(q[W-2])))); // R7

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'b110) |=> (q[W-1] == $past(q[W-1]))); // R8

  AST_WIPE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'b111) |=> (q == '0 && !ovf)); // R9

  AST_ROTATE_ONES: assert property (@(posedge clk) disable iff (rst)
    (en && (op == 3'b011 || op == 3'b100)) |=> ($countones(q) == $countones($past(q)))); // R5 R6

  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
    (en && op != 3'b000 && op != 3'b101 && op != 3'b111) |=> $stable(ovf)); // R11
endmodule

bind bitshift_reg bitshift_reg_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .op       (op),
  .din      (din),
  .q        (q),
  .ovf      (ovf),
  .asl_fire (asl_fire)
);

// File: tb/sim_bitshift_reg.sv
module sim_bitshift_reg;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst;
  logic         en;
  logic [2:0]   op;
  logic [W-1:0] din;
  logic [W-1:0] q;
  logic         ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [W-1:0] mq;
  logic         movf;

  bitshift_reg #(.W(W)) u0 (
    .clk(clk), .rst(rst), .en(en), .op(op), .din(din), .q(q), .ovf(ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [W-1:0] eq, logic eo);
    checks++;
    if (q !== eq || ovf !== eo) begin
      fails++;
      $display("FAIL %s: q=%h ovf=%b expected q=%h ovf=%b", req, q, ovf, eq, eo);
    end
  endtask

  // Bench model, written from the requirement list
  task automatic model(logic e, logic [2:0] c, logic [W-1:0] d);
    logic [W-1:0] o;
    o = mq;
    if (!e) return;
    case (c)
      3'd0: begin mq = d; movf = 0; end
      3'd1: mq = o << 1;
      3'd2: mq = o >> 1;
      3'd3: mq = (o << 1) | (o >> (W-1));
      3'd4: mq = (o >> 1) | (o << (W-1));
      3'd5: begin mq = o << 1; movf = (o[W-1] != o[W-2]); end
      3'd6: mq = $unsigned($signed(o) >>> 1);
      default: begin mq = '0; movf = 0; end
    endcase
  endtask

  task automatic step(string req, logic e, logic [2:0] c, logic [W-1:0] d);
    en = e; op = c; din = d;
    model(e, c, d);
    @(negedge clk);
    chk(req, mq, movf);
  endtask

  task automatic t_reset;
    rst = 1; en = 1; op = 3'd0; din = 8'hFF;
    @(negedge clk); @(negedge clk);
    mq = '0; movf = 0;
    chk("R1", '0, 1'b0);
    rst = 0;
  endtask

  task automatic t_load;
    step("R2", 1, 3'd0, 8'hA5);
    step("R2", 1, 3'd0, 8'h3C);
  endtask

  task automatic t_zero_fill;
    step("R2", 1, 3'd0, 8'h81);
    step("R3", 1, 3'd1, 8'h00);
    step("R3", 1, 3'd1, 8'h00);
    step("R2", 1, 3'd0, 8'h81);
    step("R4", 1, 3'd2, 8'h00);
    step("R4", 1, 3'd2, 8'h00);
  endtask

  task automatic t_rotate;
    step("R2", 1, 3'd0, 8'h81);
    step("R5", 1, 3'd3, 8'h00);
    step("R5", 1, 3'd3, 8'h00);
    step("R2", 1, 3'd0, 8'h81);
    step("R6", 1, 3'd4, 8'h00);
    step("R6", 1, 3'd4, 8'h00);
  endtask

  task automatic t_signed_left;
    step("R2", 1, 3'd0, 8'h40);
    step("R7", 1, 3'd5, 8'h00);  // 01 -> flag 1, q=80
    step("R7", 1, 3'd5, 8'h00);  // 10 -> flag 1, q=00
    step("R2", 1, 3'd0, 8'hC3);
    step("R7", 1, 3'd5, 8'h00);  // 11 -> flag 0
  endtask

  task automatic t_signed_right;
    step("R2", 1, 3'd0, 8'h90);
    step("R8", 1, 3'd6, 8'h00);
    step("R8", 1, 3'd6, 8'h00);
    step("R2", 1, 3'd0, 8'h42);
    step("R8", 1, 3'd6, 8'h00);
  endtask

  task automatic t_clear;
    step("R2", 1, 3'd0, 8'h40);
    step("R7", 1, 3'd5, 8'h00);
    step("R9", 1, 3'd7, 8'hFF);
  endtask

  task automatic t_idle;
    step("R2", 1, 3'd0, 8'h40);
    step("R7", 1, 3'd5, 8'h00);
    for (int c = 0; c < 8; c++) step("R10", 0, 3'(c), 8'h5A);
  endtask

  task automatic t_flag_hold;
    step("R2", 1, 3'd0, 8'h60);
    step("R7", 1, 3'd5, 8'h00);  // flag 1, q=C0
    step("R11", 1, 3'd1, 8'h00);
    step("R11", 1, 3'd2, 8'h00);
    step("R11", 1, 3'd3, 8'h00);
    step("R11", 1, 3'd4, 8'h00);
    step("R11", 1, 3'd6, 8'h00);
  endtask

  task automatic t_random;
    for (int k = 0; k < 400; k++) begin
      logic [2:0] c;
      c = 3'($urandom_range(0, 7));
      step(c == 0 ? "R2" : c == 1 ? "R3" : c == 2 ? "R4" : c == 3 ? "R5" :
           c == 4 ? "R6" : c == 5 ? "R7" : c == 6 ? "R8" : "R9",
           1'($urandom_range(0, 7) != 0), c, W'($urandom));
    end
  endtask

  initial begin
    en = 0; op = 0; din = 0; rst = 1; mq = 0; movf = 0;
    @(negedge clk);
    t_reset();
    t_load();
    t_zero_fill();
    t_rotate();
    t_signed_left();
    t_signed_right();
    t_clear();
    t_idle();
    t_flag_hold();
    t_random();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule